// File: doc/BRIEF.md
# Loopback Word Mover Between Two FIFOs

This block holds an outbound FIFO and an inbound FIFO, each written so that block RAM can be inferred, together with a small control machine that copies words from the outbound FIFO into the inbound one. The host pushes words into the outbound FIFO and pops them from the inbound FIFO. This gives a self-test path that exercises both queues without any line logic attached.

The copy path runs only when the loop select bit is high and both the outbound and inbound engine enables are low. Each transfer pops a word, holds it in the outbound FIFO's registered read stage for one cycle, and then pushes it. This keeps one word per clock moving while both sides are ready. A word already popped is always delivered, even when the loop select drops or an engine enable rises in that cycle.

Each FIFO has its own clear bit. A clear empties that FIFO and returns the mover to idle, and any word the mover holds is dropped.

Top module: `fifo_loop_mover`

## Requirements
- R1: After `rst`, both FIFOs report empty and not full, and `rx_rd_valid` is 0.
- R2: No word leaves the outbound FIFO unless `loop_sel` is 1 and both `tx_run` and `rx_run` are 0.
- R3: Every word accepted into the outbound FIFO is read from the inbound FIFO once, in the order it was written, with its value unchanged.
- R4: With the path active, the inbound FIFO empty and N ≤ DEPTH words queued, the mover delivers one word per cycle. The first word reaches the inbound FIFO two clock edges after the path becomes active, and the last word arrives N+1 edges after it.
- R5: The mover never pushes into a full inbound FIFO. Words that do not fit stay queued in the outbound FIFO.
- R6: A host write while `tx_full` is 1 is ignored, and the outbound FIFO contents stay unchanged.
- R7: A host read while `rx_empty` is 1 is ignored, and `rx_rd_valid` stays 0 in the next cycle.
- R8: A cycle with `tx_clr` high empties the outbound FIFO, returns the mover to idle and drops any word the mover holds.
- R9: A cycle with `rx_clr` high empties the inbound FIFO. Words written afterwards read back normally.
- R10: A word popped in the cycle before `loop_sel` is cleared is still pushed into the inbound FIFO.
- R11: With the path active and both FIFOs empty, a word written at clock edge k makes `rx_empty` fall after edge k+2.
- R12: A read accepted at edge k gives `rx_rd_valid` = 1 and the word on `rx_rd_data` after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loop_sel | input | 1 | Selects the internal loop path |
| tx_run | input | 1 | Outbound engine enable; when 1 the loop path is blocked |
| rx_run | input | 1 | Inbound engine enable; when 1 the loop path is blocked |
| tx_clr | input | 1 | Clears the outbound FIFO and idles the mover |
| rx_clr | input | 1 | Clears the inbound FIFO and idles the mover |
| tx_wr_en | input | 1 | Host write strobe for the outbound FIFO |
| tx_wr_data | input | DATA_W | Host write word |
| tx_full | output | 1 | Outbound FIFO full |
| tx_empty | output | 1 | Outbound FIFO empty |
| rx_rd_en | input | 1 | Host read strobe for the inbound FIFO |
| rx_rd_data | output | DATA_W | Word read from the inbound FIFO, registered |
| rx_rd_valid | output | 1 | `rx_rd_data` holds a word read at the previous edge |
| rx_full | output | 1 | Inbound FIFO full |
| rx_empty | output | 1 | Inbound FIFO empty |

## Verification
The bench builds the block with DEPTH = 4 and DATA_W = 32. At that small depth, random traffic often fills both FIFOs. It also often hits the case where the inbound FIFO has one free slot while the mover holds a word, so the room limit on new pops is tested many times. Thirty-two-bit random words make it very unlikely that a reordered or repeated word goes unnoticed against the bench's reference queue.

// File: rtl/loop_pkg.sv
package loop_pkg;
  typedef enum logic {
    MV_IDLE  = 1'b0,
    MV_CARRY = 1'b1
  } mover_state_t;
endpackage

// File: rtl/loop_fifo.sv
module loop_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              full,
  output logic              empty,
  output logic [$clog2(DEPTH):0] level
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [LW-1:0]     wr_ptr, rd_ptr;
  logic              wr_ok, rd_ok;

  assign level = wr_ptr - rd_ptr;
  assign full  = (level == LW'(DEPTH));
  assign empty = (level == '0);
  assign wr_ok = wr_en && !full;
  assign rd_ok = rd_en && !empty;

  // storage without reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_ok) rd_data <= mem[rd_ptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
      if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
      rd_valid <= rd_ok;
    end
  end

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en) |=> (level == $past(level)));

  a_r7_empty_read_ignored: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty) |=> !rd_valid);
endmodule

// File: rtl/loop_mover.sv
module loop_mover
  import loop_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   flush,
  input  logic                   loop_sel,
  input  logic                   tx_run,
  input  logic                   rx_run,
  input  logic                   tx_empty,
  input  logic                   rx_full,
  input  logic [$clog2(DEPTH):0] rx_level,
  input  logic                   tx_pop_vld,
  output logic                   tx_pop,
  output logic                   rx_push
);
  localparam int LW = $clog2(DEPTH) + 1;
  localparam logic [LW-1:0] ROOM_LIM = LW'(DEPTH - 2);

  mover_state_t state, state_nx;
  logic path_on, room;

  assign path_on = loop_sel && !tx_run && !rx_run;
  // while a word is held, a new pop needs space for two words
  assign room    = (state == MV_CARRY) ? (rx_level <= ROOM_LIM) : !rx_full;
  assign tx_pop  = !flush && path_on && !tx_empty && room;
  assign rx_push = !flush && (state == MV_CARRY);

  always_comb begin
    state_nx = MV_IDLE;
    if (!flush && tx_pop) state_nx = MV_CARRY;
  end

  always_ff @(posedge clk) begin
    if (flush) state <= MV_IDLE;
    else       state <= state_nx;
  end

  a_r2_gated: assert property (@(posedge clk) disable iff (flush)
    (!loop_sel || tx_run || rx_run) |-> !tx_pop);

  a_r5_no_push_full: assert property (@(posedge clk) disable iff (flush)
    rx_push |-> !rx_full);

  a_r10_popped_is_pushed: assert property (@(posedge clk) disable iff (flush)
    tx_pop |=> (rx_push || flush));

  a_r10_stage_loaded: assert property (@(posedge clk) disable iff (flush)
    rx_push |-> tx_pop_vld);

  a_r8_flush_idles: assert property (@(posedge clk)
    flush |=> !rx_push);
endmodule

// File: rtl/fifo_loop_mover.sv
module fifo_loop_mover #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loop_sel,
  input  logic              tx_run,
  input  logic              rx_run,
  input  logic              tx_clr,
  input  logic              rx_clr,
  input  logic              tx_wr_en,
  input  logic [DATA_W-1:0] tx_wr_data,
  output logic              tx_full,
  output logic              tx_empty,
  input  logic              rx_rd_en,
  output logic [DATA_W-1:0] rx_rd_data,
  output logic              rx_rd_valid,
  output logic              rx_full,
  output logic              rx_empty
);
  localparam int LW = $clog2(DEPTH) + 1;

  logic              tx_rst, rx_rst, flush;
  logic              mv_pop, mv_push, tx_pop_vld;
  logic [DATA_W-1:0] stage_data;
  logic [LW-1:0]     tx_level, rx_level;

  assign tx_rst = rst || tx_clr;
  assign rx_rst = rst || rx_clr;
  assign flush  = rst || tx_clr || rx_clr;

  loop_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk(clk), .rst(tx_rst),
    .wr_en(tx_wr_en), .wr_data(tx_wr_data),
    .rd_en(mv_pop), .rd_data(stage_data), .rd_valid(tx_pop_vld),
    .full(tx_full), .empty(tx_empty), .level(tx_level)
  );

  loop_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk(clk), .rst(rx_rst),
    .wr_en(mv_push), .wr_data(stage_data),
    .rd_en(rx_rd_en), .rd_data(rx_rd_data), .rd_valid(rx_rd_valid),
    .full(rx_full), .empty(rx_empty), .level(rx_level)
  );

  loop_mover #(.DEPTH(DEPTH)) u_mover (
    .clk(clk), .flush(flush),
    .loop_sel(loop_sel), .tx_run(tx_run), .rx_run(rx_run),
    .tx_empty(tx_empty), .rx_full(rx_full), .rx_level(rx_level),
    .tx_pop_vld(tx_pop_vld),
    .tx_pop(mv_pop), .rx_push(mv_push)
  );

  a_r1_reset_empty: assert property (@(posedge clk)
    rst |=> (tx_empty && rx_empty && !rx_rd_valid));

  a_r8_tx_clear: assert property (@(posedge clk)
    tx_clr |=> (tx_level == '0));

  a_r6_tx_bound: assert property (@(posedge clk) disable iff (rst)
    tx_level <= LW'(DEPTH));
endmodule

// File: tb/tb_fifo_loop_mover.sv
`timescale 1ns/1ps
module tb_fifo_loop_mover;
  localparam int DW = 32;
  localparam int DP = 4;

  logic clk = 1'b0;
  logic rst, loop_sel, tx_run, rx_run, tx_clr, rx_clr;
  logic tx_wr_en, rx_rd_en;
  logic [DW-1:0] tx_wr_data, rx_rd_data;
  logic tx_full, tx_empty, rx_rd_valid, rx_full, rx_empty;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  fifo_loop_mover #(.DATA_W(DW), .DEPTH(DP)) dut (
    .clk(clk), .rst(rst), .loop_sel(loop_sel), .tx_run(tx_run), .rx_run(rx_run),
    .tx_clr(tx_clr), .rx_clr(rx_clr), .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data),
    .tx_full(tx_full), .tx_empty(tx_empty), .rx_rd_en(rx_rd_en),
    .rx_rd_data(rx_rd_data), .rx_rd_valid(rx_rd_valid),
    .rx_full(rx_full), .rx_empty(rx_empty)
  );

  function automatic logic [DW-1:0] next_word(input logic [DW-1:0] base, input int idx);
    return base ^ (DW'(idx) * 32'h9E37_79B9);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [DW-1:0] d);
    tx_wr_en = 1'b1; tx_wr_data = d;
    tick();
    tx_wr_en = 1'b0;
  endtask

  task automatic read_one(input string req);
    logic [DW-1:0] e;
    rx_rd_en = 1'b1;
    tick();
    rx_rd_en = 1'b0;
    e = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
    chk(rx_rd_valid === 1'b1, {req, " R12 valid"}, DW'(rx_rd_valid), 1);
    chk(rx_rd_data === e, req, rx_rd_data, e);
  endtask

  task automatic drain(input int n, input string req);
    int got = 0;
    for (int t = 0; t < 200 && got < n; t++) begin
      if (!rx_empty) begin read_one(req); got++; end
      else tick();
    end
    chk(got == n, {req, " drain count"}, DW'(got), DW'(n));
  endtask

  initial begin
    #(100000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [DW-1:0] w;
    void'($urandom(32'd20240611));
    rst = 1'b1; loop_sel = 1'b0; tx_run = 1'b0; rx_run = 1'b0;
    tx_clr = 1'b0; rx_clr = 1'b0; tx_wr_en = 1'b0; rx_rd_en = 1'b0;
    tx_wr_data = '0;
    @(negedge clk); tick(); tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk(tx_empty === 1'b1, "R1 tx_empty", DW'(tx_empty), 1);
    chk(rx_empty === 1'b1, "R1 rx_empty", DW'(rx_empty), 1);
    chk(tx_full === 1'b0 && rx_full === 1'b0, "R1 full flags", DW'({tx_full, rx_full}), 0);
    chk(rx_rd_valid === 1'b0, "R1 rd_valid", DW'(rx_rd_valid), 0);

    // R6: fill outbound with path off; fifth write ignored
    for (int i = 0; i < DP + 1; i++) begin
      w = next_word(32'hA000_0000, i);
      if (i < DP) exp_q.push_back(w);
      wr(w);
    end
    chk(tx_full === 1'b1, "R6 tx_full", DW'(tx_full), 1);
    // R2: blocked by each gate
    tick(); tick();
    chk(rx_empty === 1'b1, "R2 loop_sel=0", DW'(rx_empty), 1);
    loop_sel = 1'b1; tx_run = 1'b1;
    tick(); tick(); tick();
    chk(rx_empty === 1'b1 && tx_full === 1'b1, "R2 tx_run=1", DW'(rx_empty), 1);
    tx_run = 1'b0; rx_run = 1'b1;
    tick(); tick(); tick();
    chk(rx_empty === 1'b1 && tx_full === 1'b1, "R2 rx_run=1", DW'(rx_empty), 1);
    // R4 throughput: path opens now
    rx_run = 1'b0;
    tick(); tick(); tick(); tick();
    chk(rx_full === 1'b0 && tx_empty === 1'b1, "R4 after 4 edges", DW'({rx_full, tx_empty}), 1);
    tick();
    chk(rx_full === 1'b1, "R4 last word after N+1 edges", DW'(rx_full), 1);
    // R3 order, R6 dropped fifth word absent
    drain(DP, "R3 directed order");
    chk(rx_empty === 1'b1, "R6 extra word not stored", DW'(rx_empty), 1);
    // R7 read on empty
    rx_rd_en = 1'b1; tick(); rx_rd_en = 1'b0;
    chk(rx_rd_valid === 1'b0, "R7 empty read ignored", DW'(rx_rd_valid), 0);
    tick();

    // R5: 2*DP words back to back, inbound never read
    for (int i = 0; i < 2 * DP; i++) begin
      w = next_word(32'hB100_0000, i);
      exp_q.push_back(w);
      wr(w);
    end
    for (int i = 0; i < 6; i++) tick();
    chk(rx_full === 1'b1 && tx_full === 1'b1, "R5 both full, none lost", DW'({rx_full, tx_full}), 3);
    drain(2 * DP, "R5 order after back-pressure");
    tick();

    // R11 latency and R10 loop_sel dropped with word held
    w = 32'hC0DE_0011; exp_q.push_back(w);
    wr(w);                      // edge k
    chk(rx_empty === 1'b1, "R11 not yet after k", DW'(rx_empty), 1);
    tick();                     // edge k+1: pop
    chk(rx_empty === 1'b1, "R11 not yet after k+1", DW'(rx_empty), 1);
    loop_sel = 1'b0;
    tick();                     // edge k+2: push
    chk(rx_empty === 1'b0, "R10 R11 held word delivered", DW'(rx_empty), 0);
    chk(tx_empty === 1'b1, "R10 outbound drained", DW'(tx_empty), 1);
    read_one("R10 data");
    w = 32'hC0DE_0022; exp_q.push_back(w);
    wr(w);
    for (int i = 0; i < 4; i++) tick();
    chk(rx_empty === 1'b1 && tx_empty === 1'b0, "R2 loop_sel low holds word", DW'({rx_empty, tx_empty}), 2);
    loop_sel = 1'b1;
    drain(1, "R2 released word");
    tick();

    // R8: clear while mover holds a word
    wr(32'hDEAD_0001);          // edge k
    tick();                     // edge k+1: popped
    tx_clr = 1'b1;
    tick();                     // clear edge
    tx_clr = 1'b0;
    tick(); tick(); tick();
    chk(rx_empty === 1'b1 && tx_empty === 1'b1, "R8 held word dropped", DW'({rx_empty, tx_empty}), 3);
    loop_sel = 1'b0;
    wr(32'hDEAD_0002); wr(32'hDEAD_0003); wr(32'hDEAD_0004);
    tx_clr = 1'b1; tick(); tx_clr = 1'b0;
    chk(tx_empty === 1'b1, "R8 outbound emptied", DW'(tx_empty), 1);
    loop_sel = 1'b1;
    for (int i = 0; i < 4; i++) tick();
    chk(rx_empty === 1'b1, "R8 nothing moved after clear", DW'(rx_empty), 1);

    // R9: inbound clear
    wr(32'hE000_0001); wr(32'hE000_0002);
    for (int i = 0; i < 4; i++) tick();
    chk(rx_empty === 1'b0, "R9 inbound loaded", DW'(rx_empty), 0);
    rx_clr = 1'b1; tick(); rx_clr = 1'b0;
    chk(rx_empty === 1'b1, "R9 inbound emptied", DW'(rx_empty), 1);
    w = 32'hE000_0003; exp_q.push_back(w);
    wr(w);
    drain(1, "R9 new word after clear");
    tick();

    // random traffic, R3 against reference queue
    for (int i = 0; i < 600; i++) begin
      if (rx_rd_valid) begin
        logic [DW-1:0] e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
        chk(rx_rd_data === e, "R3 random order", rx_rd_data, e);
      end
      tx_wr_en   = ($urandom % 2) == 0;
      tx_wr_data = $urandom;
      if (tx_wr_en && !tx_full) exp_q.push_back(tx_wr_data);
      rx_rd_en = ($urandom % 3) != 0;
      loop_sel = ($urandom % 8) != 0;
      tx_run   = ($urandom % 10) == 0;
      rx_run   = ($urandom % 10) == 0;
      tick();
    end
    tx_wr_en = 1'b0; rx_rd_en = 1'b0;
    loop_sel = 1'b1; tx_run = 1'b0; rx_run = 1'b0;
    if (rx_rd_valid) begin
      logic [DW-1:0] e;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
      chk(rx_rd_data === e, "R3 random order", rx_rd_data, e);
    end
    tick();
    drain(exp_q.size(), "R3 random drain");
    tick(); tick(); tick();
    chk(exp_q.size() == 0 && rx_empty === 1'b1 && tx_empty === 1'b1,
        "R3 all words delivered once", DW'(exp_q.size()), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule